// File: doc/BRIEF.md
# Debug Trigger Match and Chaining Unit

This block watches the fetch, load and store event streams of a core. It checks each event against ten configurable debug triggers, and for every instruction it reports which triggers fire. Each trigger is tied to one event source. The ten triggers form five fixed pairs:

| Pair | Triggers | Sources |
|------|----------|---------|
| 0 | 0, 1 | fetch, fetch |
| 1 | 2, 3 | store, store |
| 2 | 4, 5 | load, load |
| 3 | 6, 7 | fetch, store |
| 4 | 8, 9 | fetch, load |

A trigger compares its 64-bit value against the fetch PC or the memory address, using one of four unsigned compare modes. Pairs can be chained. In a chained pair, the two triggers fire only together, and only when both ask for the same trap timing.

Configuration arrives on two write ports, each a valid/index/word triple. One port serves the four fetch triggers and the other serves the six memory triggers. The fire flags are registered one cycle after the event. They are split into "trap at this instruction" and "trap at the next instruction". A combined hit flag and a debug-mode-entry flag accompany them.

Top module: `trg_unit`

## Requirements
- R1: After reset every trigger is unarmed, so no trigger fires before it has been written, and all outputs are 0.
- R2: The match type sits in word bits [1:0], and the compare value sits in bits [69:6]. All compares are unsigned.
  - Type 0 matches when the address equals the value.
  - Type 1 is a masked match. The mask covers the value's trailing ones plus the next bit above them. For example, value 0x1003 covers 0x1000 to 0x1007.
  - Type 2 matches when the address is greater than or equal to the value.
  - Type 3 matches when the address is less than the value.
- R3: A trigger whose select bit (word bit 2) is 1 asks for a data compare. Data compares are unsupported, so that trigger never matches.
- R4: A configuration word is stored only while its port's valid input is high.
  - Fetch index 0..3 selects triggers 0, 1, 6 and 8.
  - Memory index 0..5 selects triggers 2, 3, 4, 5, 7 and 9.
  - Memory indices 6 and 7 write nothing.
- R5: A fetch trigger compares only the fetch PC, a load trigger only the load address, and a store trigger only the store address. Each compares only while its own event valid is high. Fire outputs appear on the cycle after the event.
- R6: When the chain bit (word bit 5) of the even trigger of a pair is 1, neither trigger of that pair fires unless both match in the same cycle.
- R7: In a chained pair whose two timing bits differ, neither trigger fires.
- R8: The chain bit of the store/store pair (triggers 2 and 3) is ignored; those two triggers always fire on their own matches.
- R9: The timing bit (word bit 3) steers a firing trigger:
  - 0 sends it to the fire-now output.
  - 1 sends it to the fire-next output.
  - A trigger never appears on both.
- R10: Fire-output bit positions follow the index order of R4.
  - `hit_any` is the OR of every fire flag.
  - `hit_dbg` is 1 when any firing trigger has its action bit (word bit 4) set.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fcfg_vld | input | 1 | Fetch-trigger configuration write strobe |
| fcfg_idx | input | 2 | Fetch-trigger index |
| fcfg_word | input | 70 | Configuration word for the fetch trigger |
| mcfg_vld | input | 1 | Memory-trigger configuration write strobe |
| mcfg_idx | input | 3 | Memory-trigger index |
| mcfg_word | input | 70 | Configuration word for the memory trigger |
| fetch_vld | input | 1 | Fetch event valid |
| fetch_pc | input | 64 | Fetch PC |
| ld_vld | input | 1 | Load event valid |
| ld_addr | input | 64 | Load address |
| st_vld | input | 1 | Store event valid |
| st_addr | input | 64 | Store address |
| fetch_fire_now | output | 4 | Fetch triggers firing at this instruction |
| fetch_fire_next | output | 4 | Fetch triggers firing at the next instruction |
| mem_fire_now | output | 6 | Memory triggers firing at this instruction |
| mem_fire_next | output | 6 | Memory triggers firing at the next instruction |
| hit_any | output | 1 | Any trigger fired |
| hit_dbg | output | 1 | A fired trigger requests debug-mode entry |

## Verification
A wrong configuration register shows up on the fire outputs on the first event after the faulty write. The fault may be a misrouted index, a write taken without valid, or a wrong field position. The symptom is a missing or misplaced fire bit, exactly one cycle later. Faults in the chaining state show only when the partner trigger is considered. A stuck chain enable or a swapped timing compare is therefore exposed by events that hit one member of a pair, both members, or both with unequal timing. Each of those cases becomes visible one cycle after the event.

// File: rtl/trg_pkg.sv
package trg_pkg;
  localparam int XLEN   = 64;
  localparam int NTRIG  = 10;
  localparam int NGRP   = NTRIG / 2;
  localparam int NFETCH = 4;
  localparam int NMEM   = NTRIG - NFETCH;
  localparam int FIDX_W = $clog2(NFETCH);
  localparam int MIDX_W = $clog2(NMEM);
  localparam int CFGW   = XLEN + 6;
  localparam int STST_GRP = 1;

  typedef enum logic [1:0] {SRC_FETCH = 2'd0, SRC_LOAD = 2'd1, SRC_STORE = 2'd2} src_e;

  typedef struct packed {
    logic [XLEN-1:0] val;
    logic            chain;
    logic            action;
    logic            timing;
    logic            sel;
    logic [1:0]      mtype;
  } cfg_t;

  function automatic src_e trig_src(input int i);
    case (i)
      2, 3, 7: return SRC_STORE;
      4, 5, 9: return SRC_LOAD;
      default: return SRC_FETCH;
    endcase
  endfunction

  // position of a trigger within its write port
  function automatic int port_slot(input int i);
    case (i)
      0, 2:    return 0;
      1, 3:    return 1;
      4, 6:    return 2;
      5, 8:    return 3;
      7:       return 4;
      9:       return 5;
      default: return 0;
    endcase
  endfunction

  function automatic int fetch_trig(input int j);
    return (j < 2) ? j : ((j == 2) ? 6 : 8);
  endfunction

  function automatic int mem_trig(input int k);
    return (k < 4) ? k + 2 : ((k == 4) ? 7 : 9);
  endfunction

  function automatic logic cmp_hit(input cfg_t c, input logic [XLEN-1:0] a);
    logic [XLEN-1:0] m;
    m = c.val ^ (c.val + 1'b1);
    case (c.mtype)
      2'd0:    return a == c.val;
      2'd1:    return (a & ~m) == (c.val & ~m);
      2'd2:    return a >= c.val;
      default: return a < c.val;
    endcase
  endfunction
endpackage

// File: rtl/trg_cfg_bank.sv
module trg_cfg_bank
  import trg_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     fcfg_vld,
  input  logic [FIDX_W-1:0]        fcfg_idx,
  input  logic [CFGW-1:0]          fcfg_word,
  input  logic                     mcfg_vld,
  input  logic [MIDX_W-1:0]        mcfg_idx,
  input  logic [CFGW-1:0]          mcfg_word,
  output cfg_t [NTRIG-1:0]         cfg_q,
  output logic [NTRIG-1:0]         armed_q
);
  for (genvar i = 0; i < NTRIG; i++) begin : g_reg
    localparam bit IS_F = (trig_src(i) == SRC_FETCH);
    localparam int SLOT = port_slot(i);
    logic we;
    if (IS_F) begin : g_f
      assign we = fcfg_vld && (fcfg_idx == FIDX_W'(SLOT));
    end else begin : g_m
      assign we = mcfg_vld && (mcfg_idx == MIDX_W'(SLOT));
    end
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cfg_q[i]   <= '0;
        armed_q[i] <= 1'b0;
      end else if (we) begin
        cfg_q[i]   <= IS_F ? cfg_t'(fcfg_word) : cfg_t'(mcfg_word);
        armed_q[i] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/trg_match.sv
module trg_match
  import trg_pkg::*;
(
  input  cfg_t [NTRIG-1:0]  cfg,
  input  logic [NTRIG-1:0]  armed,
  input  logic              fetch_vld,
  input  logic [XLEN-1:0]   fetch_pc,
  input  logic              ld_vld,
  input  logic [XLEN-1:0]   ld_addr,
  input  logic              st_vld,
  input  logic [XLEN-1:0]   st_addr,
  output logic [NTRIG-1:0]  raw_hit
);
  for (genvar i = 0; i < NTRIG; i++) begin : g_cmp
    localparam src_e SRC = trig_src(i);
    logic            ev;
    logic [XLEN-1:0] adr;
    if (SRC == SRC_FETCH) begin : g_f
      assign ev = fetch_vld; assign adr = fetch_pc;
    end else if (SRC == SRC_LOAD) begin : g_l
      assign ev = ld_vld;    assign adr = ld_addr;
    end else begin : g_s
      assign ev = st_vld;    assign adr = st_addr;
    end
    assign raw_hit[i] = ev && armed[i] && !cfg[i].sel && cmp_hit(cfg[i], adr);
  end
endmodule

// File: rtl/trg_chain.sv
module trg_chain
  import trg_pkg::*;
(
  input  cfg_t [NTRIG-1:0]  cfg,
  input  logic [NTRIG-1:0]  raw_hit,
  output logic [NGRP-1:0]   grp_chain,
  output logic [NTRIG-1:0]  fire_now,
  output logic [NTRIG-1:0]  fire_next
);
  for (genvar g = 0; g < NGRP; g++) begin : g_pair
    localparam int E = 2 * g;
    localparam int O = 2 * g + 1;
    logic both, fe, fo;
    if (g == STST_GRP) begin : g_nochain
      assign grp_chain[g] = 1'b0;
    end else begin : g_chain
      assign grp_chain[g] = cfg[E].chain;
    end
    assign both = raw_hit[E] && raw_hit[O] && (cfg[E].timing == cfg[O].timing);
    assign fe   = grp_chain[g] ? both : raw_hit[E];
    assign fo   = grp_chain[g] ? both : raw_hit[O];
    assign fire_now[E]  = fe && !cfg[E].timing;
    assign fire_next[E] = fe &&  cfg[E].timing;
    assign fire_now[O]  = fo && !cfg[O].timing;
    assign fire_next[O] = fo &&  cfg[O].timing;
  end
endmodule

// File: rtl/trg_unit.sv
module trg_unit
  import trg_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fcfg_vld,
  input  logic [FIDX_W-1:0]   fcfg_idx,
  input  logic [CFGW-1:0]     fcfg_word,
  input  logic                mcfg_vld,
  input  logic [MIDX_W-1:0]   mcfg_idx,
  input  logic [CFGW-1:0]     mcfg_word,
  input  logic                fetch_vld,
  input  logic [XLEN-1:0]     fetch_pc,
  input  logic                ld_vld,
  input  logic [XLEN-1:0]     ld_addr,
  input  logic                st_vld,
  input  logic [XLEN-1:0]     st_addr,
  output logic [NFETCH-1:0]   fetch_fire_now,
  output logic [NFETCH-1:0]   fetch_fire_next,
  output logic [NMEM-1:0]     mem_fire_now,
  output logic [NMEM-1:0]     mem_fire_next,
  output logic                hit_any,
  output logic                hit_dbg
);
  cfg_t [NTRIG-1:0] cfg_q;
  logic [NTRIG-1:0] armed_q;
  logic [NTRIG-1:0] raw_hit;
  logic [NGRP-1:0]  grp_chain;
  logic [NTRIG-1:0] fire_now, fire_next;
  logic [NTRIG-1:0] trg_timing, trg_sel, trg_action;
  logic [NTRIG-1:0] now_q, next_q;

  for (genvar i = 0; i < NTRIG; i++) begin : g_fld
    assign trg_timing[i] = cfg_q[i].timing;
    assign trg_sel[i]    = cfg_q[i].sel;
    assign trg_action[i] = cfg_q[i].action;
  end

  trg_cfg_bank u_bank (
    .clk, .rst_n, .fcfg_vld, .fcfg_idx, .fcfg_word,
    .mcfg_vld, .mcfg_idx, .mcfg_word, .cfg_q, .armed_q
  );

  trg_match u_match (
    .cfg(cfg_q), .armed(armed_q), .fetch_vld, .fetch_pc,
    .ld_vld, .ld_addr, .st_vld, .st_addr, .raw_hit
  );

  trg_chain u_chain (
    .cfg(cfg_q), .raw_hit, .grp_chain, .fire_now, .fire_next
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      now_q   <= '0;
      next_q  <= '0;
      hit_any <= 1'b0;
      hit_dbg <= 1'b0;
    end else begin
      now_q   <= fire_now;
      next_q  <= fire_next;
      hit_any <= |(fire_now | fire_next);
      hit_dbg <= |((fire_now | fire_next) & trg_action);
    end
  end

  for (genvar j = 0; j < NFETCH; j++) begin : g_fout
    assign fetch_fire_now[j]  = now_q[fetch_trig(j)];
    assign fetch_fire_next[j] = next_q[fetch_trig(j)];
  end
  for (genvar k = 0; k < NMEM; k++) begin : g_mout
    assign mem_fire_now[k]  = now_q[mem_trig(k)];
    assign mem_fire_next[k] = next_q[mem_trig(k)];
  end
endmodule

// File: rtl/trg_unit_chk.sv
module trg_unit_chk
  import trg_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               fetch_vld,
  input logic               ld_vld,
  input logic               st_vld,
  input logic [NTRIG-1:0]   raw_hit,
  input logic [NGRP-1:0]    grp_chain,
  input logic [NTRIG-1:0]   trg_timing,
  input logic [NTRIG-1:0]   trg_sel,
  input logic [NFETCH-1:0]  fetch_fire_now,
  input logic [NFETCH-1:0]  fetch_fire_next,
  input logic [NMEM-1:0]    mem_fire_now,
  input logic [NMEM-1:0]    mem_fire_next,
  input logic               hit_any,
  input logic               hit_dbg
);
  // R3
  sel_no_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trg_sel & raw_hit) == '0);

  // R5
  fetch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_vld |=> (fetch_fire_now == '0 && fetch_fire_next == '0));

  // R5
  mem_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_vld && !st_vld) |=> (mem_fire_now == '0 && mem_fire_next == '0));

  // R6
  chain_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_chain[0] && !(raw_hit[0] && raw_hit[1])) |=>
      (fetch_fire_now[1:0] == 2'b00 && fetch_fire_next[1:0] == 2'b00));

  // R7
  chain_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_chain[3] && (trg_timing[6] != trg_timing[7])) |=>
      (!fetch_fire_now[2] && !fetch_fire_next[2] && !mem_fire_now[4] && !mem_fire_next[4]));

  // R8
  stst_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_hit[2] && !trg_timing[2]) |=> mem_fire_now[0]);

  // R9
  slot_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((fetch_fire_now & fetch_fire_next) == '0) && ((mem_fire_now & mem_fire_next) == '0));

  // R10
  dbg_implies_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_dbg |-> hit_any);

  // R10
  hit_has_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_any |-> (|{fetch_fire_now, fetch_fire_next, mem_fire_now, mem_fire_next}));
endmodule

bind trg_unit trg_unit_chk u_chk (.*);

// File: tb/tb_trg_unit.sv
module tb_trg_unit;
  import trg_pkg::*;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n;
  logic fcfg_vld, mcfg_vld;
  logic [1:0] fcfg_idx;
  logic [2:0] mcfg_idx;
  logic [69:0] fcfg_word, mcfg_word;
  logic fetch_vld, ld_vld, st_vld;
  logic [63:0] fetch_pc, ld_addr, st_addr;
  logic [3:0] fetch_fire_now, fetch_fire_next;
  logic [5:0] mem_fire_now, mem_fire_next;
  logic hit_any, hit_dbg;

  int checks = 0;
  int failures = 0;

  trg_unit dut (.*);

  typedef struct packed {
    logic [1:0]  mt;
    logic [63:0] val;
    logic [63:0] pc;
    logic        exp;
  } vec_t;

  localparam vec_t TBL [9] = '{
    '{2'd0, 64'h1000, 64'h1000, 1'b1},
    '{2'd0, 64'h1000, 64'h1001, 1'b0},
    '{2'd1, 64'h1003, 64'h1007, 1'b1},
    '{2'd1, 64'h1003, 64'h1000, 1'b1},
    '{2'd1, 64'h1003, 64'h1008, 1'b0},
    '{2'd2, 64'h2000, 64'h2000, 1'b1},
    '{2'd2, 64'h2000, 64'h1fff, 1'b0},
    '{2'd3, 64'h2000, 64'h1fff, 1'b1},
    '{2'd3, 64'h2000, 64'h2000, 1'b0}
  };

  function automatic logic [69:0] mkw(input logic [1:0] mt, input logic sel, input logic tim,
                                      input logic act, input logic ch, input logic [63:0] v);
    return {v, ch, act, tim, sel, mt};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_f(input logic v, input logic [1:0] idx, input logic [69:0] w);
    @(negedge clk);
    fcfg_vld = v; fcfg_idx = idx; fcfg_word = w;
    @(negedge clk);
    fcfg_vld = 1'b0;
  endtask

  task automatic wr_m(input logic v, input logic [2:0] idx, input logic [69:0] w);
    @(negedge clk);
    mcfg_vld = v; mcfg_idx = idx; mcfg_word = w;
    @(negedge clk);
    mcfg_vld = 1'b0;
  endtask

  task automatic clear_all();
    for (int j = 0; j < 4; j++) wr_f(1'b1, 2'(j), mkw(2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 64'h0));
    for (int k = 0; k < 6; k++) wr_m(1'b1, 3'(k), mkw(2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 64'h0));
  endtask

  // drive an event before an edge, sample one time unit after that edge
  task automatic ev(input logic fv, input logic [63:0] pc, input logic lv, input logic [63:0] la,
                    input logic sv, input logic [63:0] sa);
    @(negedge clk);
    fetch_vld = fv; fetch_pc = pc; ld_vld = lv; ld_addr = la; st_vld = sv; st_addr = sa;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    fetch_vld = 1'b0; ld_vld = 1'b0; st_vld = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    fcfg_vld = 0; mcfg_vld = 0; fcfg_idx = 0; mcfg_idx = 0; fcfg_word = 0; mcfg_word = 0;
    fetch_vld = 0; ld_vld = 0; st_vld = 0; fetch_pc = 0; ld_addr = 0; st_addr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: reset state and unarmed triggers with all-zero config
    chk("R1 outputs", {hit_any, hit_dbg, fetch_fire_now, fetch_fire_next, mem_fire_now, mem_fire_next}, 0);
    ev(1, 64'h0, 1, 64'h0, 1, 64'h0);
    chk("R1 unarmed", {hit_any, fetch_fire_now, mem_fire_now}, 0);
    idle();

    clear_all();
    // R2: match-type table on fetch trigger 0
    foreach (TBL[n]) begin
      wr_f(1'b1, 2'd0, mkw(TBL[n].mt, 1'b0, 1'b0, 1'b0, 1'b0, TBL[n].val));
      ev(1, TBL[n].pc, 0, 0, 0, 0);
      chk("R2 match", {fetch_fire_now, hit_any}, {3'b000, TBL[n].exp, TBL[n].exp});
      idle();
    end

    // R3: select bit blocks a load trigger (mem idx 2 -> trigger 4)
    clear_all();
    wr_m(1'b1, 3'd2, mkw(2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 64'h40));
    ev(0, 0, 1, 64'h40, 0, 0);
    chk("R3 sel blocks", mem_fire_now, 6'b000000);
    idle();
    wr_m(1'b1, 3'd2, mkw(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 64'h40));
    ev(0, 0, 1, 64'h40, 0, 0);
    chk("R3 sel clear", mem_fire_now, 6'b000100);
    idle();

    // R4: write without valid has no effect; index mapping
    clear_all();
    wr_f(1'b0, 2'd1, mkw(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 64'h77));
    ev(1, 64'h77, 0, 0, 0, 0);
    chk("R4 no valid", fetch_fire_now, 4'b0000);
    idle();
    wr_f(1'b1, 2'd2, mkw(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 64'h77));
    ev(1, 64'h77, 0, 0, 0, 0);
    chk("R4 fetch idx2", fetch_fire_now, 4'b0100);
    idle();
    wr_m(1'b1, 3'd6, mkw(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 64'h88));
    wr_m(1'b1, 3'd7, mkw(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 64'h88));
    ev(0, 0, 1, 64'h88, 1, 64'h88);
    chk("R4 mem idx 6/7 ignored", {mem_fire_now, mem_fire_next}, 0);
    idle();

    // R5: source routing (store trigger idx0 ignores load and fetch)
    clear_all();
    wr_m(1'b1, 3'd0, mkw(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 64'h300));
    ev(1, 64'h300, 1, 64'h300, 0, 64'h300);
    chk("R5 wrong source", {fetch_fire_now, mem_fire_now}, 0);
    idle();
    ev(0, 0, 0, 0, 1, 64'h300);
    chk("R5 store hit", mem_fire_now, 6'b000001);
    idle();
    @(posedge clk); #1;
    chk("R5 one cycle only", mem_fire_now, 6'b000000);

    // R6: chained fetch pair 0/1
    clear_all();
    wr_f(1'b1, 2'd0, mkw(2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 64'h100));
    wr_f(1'b1, 2'd1, mkw(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 64'h200));
    ev(1, 64'h100, 0, 0, 0, 0);
    chk("R6 one member", {fetch_fire_now, hit_any}, 0);
    idle();
    wr_f(1'b1, 2'd1, mkw(2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 64'h80));
    ev(1, 64'h100, 0, 0, 0, 0);
    chk("R6 both", fetch_fire_now, 4'b0011);
    idle();

    // R7: differing timing in chained pair
    wr_f(1'b1, 2'd1, mkw(2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 64'h80));
    ev(1, 64'h100, 0, 0, 0, 0);
    chk("R7 timing mismatch", {fetch_fire_now, fetch_fire_next}, 0);
    idle();

    // R6 across sources: pair 4 (fetch idx3 = trigger 8, mem idx5 = trigger 9)
    clear_all();
    wr_f(1'b1, 2'd3, mkw(2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 64'h500));
    wr_m(1'b1, 3'd5, mkw(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 64'h600));
    ev(1, 64'h500, 1, 64'h600, 0, 0);
    chk("R6 fetch+load", {fetch_fire_now, mem_fire_now}, {4'b1000, 6'b100000});
    idle();
    ev(1, 64'h500, 0, 0, 0, 0);
    chk("R6 fetch alone", fetch_fire_now, 4'b0000);
    idle();

    // R8: store/store chain ignored
    clear_all();
    wr_m(1'b1, 3'd0, mkw(2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 64'h300));
    wr_m(1'b1, 3'd1, mkw(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 64'h999));
    ev(0, 0, 0, 0, 1, 64'h300);
    chk("R8 store chain ignored", mem_fire_now, 6'b000001);
    idle();

    // R9, R10: timing steering, action flag
    clear_all();
    wr_f(1'b1, 2'd1, mkw(2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 64'h44));
    ev(1, 64'h44, 0, 0, 0, 0);
    chk("R9 next slot", {fetch_fire_now, fetch_fire_next}, {4'b0000, 4'b0010});
    chk("R10 dbg set", {hit_any, hit_dbg}, 2'b11);
    idle();
    wr_m(1'b1, 3'd3, mkw(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 64'h55));
    ev(0, 0, 1, 64'h55, 0, 0);
    chk("R9 now slot", {mem_fire_now, mem_fire_next}, {6'b001000, 6'b000000});
    chk("R10 dbg clear", {hit_any, hit_dbg}, 2'b10);
    idle();
    @(posedge clk); #1;
    chk("R10 quiet", {hit_any, hit_dbg}, 2'b00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule